// File: doc/BRIEF.md
# CPU Debug Register Bridge

This block connects a debug network slave port, which moves 16-bit registers, to the debug port of a processor, which reads and writes 32-bit debug registers by address in the way a memory port does. Debug-side addresses from 0x400 upward reach the processor. Each processor register appears as a pair of adjacent 16-bit debug registers. The bridge does not decode processor register numbers. Host software gives those registers their meaning.

Addresses below 0x400 belong to the bridge itself. One control word there lets the debugger hold the processor in a stalled state and release it, and it reports whether the processor is stalled now. When the processor enters the stalled state, for example on a breakpoint, the bridge sends a one-cycle event toward the debugger.

Whole-word reads and writes look nearly atomic. Reading the low half fetches the complete word and keeps its upper half. Writing the low half only stages it, and writing the high half sends the complete word to the processor in one write.

Top module: `dbg_reg_bridge`

## Requirements
- R1: Writing local address 0x0 sets `cpu_stall_req` to bit 0 of the written data. Reading local address 0x0 returns the stall request in bit 0, `cpu_stalled` in bit 1, and zero in all other bits.
- R2: Each rising edge of `cpu_stalled` sampled at a clock edge makes `dbg_event` high for exactly one cycle, starting in the following cycle. The event does not repeat while the processor stays stalled.
- R3: A forwarded address A (A >= 0x400) selects processor register index ((A - 0x400) >> 1), truncated to CPU_AW bits and driven on `cpu_addr`. Bit 0 of A selects the low half (0) or the high half (1).
- R4: A read of a low half performs one processor read. It returns bits 15:0 of that word and keeps bits 31:16.
- R5: A read of a high half returns the kept bits 31:16 from the last low-half read and makes no processor access.
- R6: A write of a low half is staged inside the bridge and makes no processor access.
- R7: A write of a high half makes exactly one processor write, with the new data in bits 31:16 and the staged low half in bits 15:0.
- R8: `cpu_valid`, `cpu_we`, `cpu_addr` and `cpu_wdata` stay steady until `cpu_ack`. At most one forwarded access is outstanding. `dbg_req_ready` is low from the cycle after acceptance until the response has been given.
- R9: `dbg_rsp_valid` is high for exactly one cycle per accepted request. For requests that make no processor access it is high in the cycle after acceptance. For processor accesses it is high in the cycle after `cpu_ack`. Write responses carry zero data.
- R10: Local addresses other than 0x0 read as zero, and writes to them change nothing.
- R11: After reset, `dbg_req_ready` is high and `dbg_rsp_valid`, `dbg_event`, `cpu_stall_req` and `cpu_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Bridge idle; request accepted this cycle if valid |
| dbg_req_we | input | 1 | 1 = write, 0 = read |
| dbg_req_addr | input | AW | Debug register address |
| dbg_req_wdata | input | DW | Debug write data |
| dbg_rsp_valid | output | 1 | One-cycle response strobe |
| dbg_rsp_rdata | output | DW | Read data returned with the response |
| dbg_event | output | 1 | One-cycle pulse on entry into the stalled state |
| cpu_stall_req | output | 1 | Stall request to the processor |
| cpu_stalled | input | 1 | Processor stalled status |
| cpu_valid | output | 1 | Processor access request |
| cpu_we | output | 1 | Processor access is a write |
| cpu_addr | output | CPU_AW | Processor debug register index |
| cpu_wdata | output | 2*DW | Processor write data |
| cpu_ack | input | 1 | Processor completes the access |
| cpu_rdata | input | 2*DW | Processor read data, valid with `cpu_ack` |

## Verification
The assertions assume that the processor raises `cpu_ack` only while `cpu_valid` is high and for one cycle per access, and that a debug request stays presented until `dbg_req_ready` takes it. The bench's processor model acknowledges only a pending access, drops the acknowledge after a single cycle, and can wait zero or several cycles first. The bench driver lowers `dbg_req_valid` right after acceptance and waits for each response before it sends the next request. `cpu_stalled` changes only on the falling clock edge, so each of its rising edges is sampled cleanly.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } xfer_st_e;

  localparam int unsigned FWD_BASE = 32'h0000_0400;
  localparam int unsigned CTRL_ADDR = 32'h0000_0000;
endpackage

// File: rtl/dbgb_rst_sync.sv
module dbgb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dbgb_stall.sv
module dbgb_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic cpu_stalled,
  output logic stall_req,
  output logic stalled_now,
  output logic stall_evt
);
  logic req_q, req_d;
  logic seen_q;
  logic evt_q, evt_d;

  always_comb begin
    req_d = req_q;
    if (wr_en) req_d = wr_bit;
    evt_d = cpu_stalled & ~seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      seen_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      seen_q <= cpu_stalled;
      evt_q  <= evt_d;
    end
  end

  assign stall_req   = req_q;
  assign stalled_now = cpu_stalled;
  assign stall_evt   = evt_q;
endmodule

// File: rtl/dbgb_xfer.sv
module dbgb_xfer
  import dbgb_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int CPU_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [DW-1:0]     ctrl_word,
  output logic              ctrl_wr,
  output logic              ctrl_wbit,
  output logic              cpu_valid,
  output logic              cpu_we,
  output logic [CPU_AW-1:0] cpu_addr,
  output logic [2*DW-1:0]   cpu_wdata,
  input  logic              cpu_ack,
  input  logic [2*DW-1:0]   cpu_rdata
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] BASE = AW'(FWD_BASE);
  localparam logic [AW-1:0] CTRL = AW'(CTRL_ADDR);

  xfer_st_e           st_q, st_d;
  logic               cv_q, cv_d;
  logic               cwe_q, cwe_d;
  logic [CPU_AW-1:0]  cad_q, cad_d;
  logic [CW-1:0]      cwd_q, cwd_d;
  logic [DW-1:0]      upper_q, upper_d;
  logic [DW-1:0]      stage_q, stage_d;
  logic [DW-1:0]      rd_q, rd_d;

  logic               accept;
  logic               is_fwd;
  logic [AW-1:0]      offs;
  logic               hi_half;
  logic [CPU_AW-1:0]  idx;

  assign accept  = req_valid && (st_q == ST_IDLE);
  assign is_fwd  = req_addr >= BASE;
  assign offs    = req_addr - BASE;
  assign hi_half = offs[0];
  assign idx     = offs[CPU_AW:1];

  always_comb begin
    st_d      = st_q;
    cv_d      = cv_q;
    cwe_d     = cwe_q;
    cad_d     = cad_q;
    cwd_d     = cwd_q;
    upper_d   = upper_q;
    stage_d   = stage_q;
    rd_d      = rd_q;
    ctrl_wr   = 1'b0;
    ctrl_wbit = req_wdata[0];
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          rd_d = '0;
          if (!is_fwd) begin
            if (req_addr == CTRL) begin
              if (req_we) ctrl_wr = 1'b1;
              else        rd_d    = ctrl_word;
            end
            st_d = ST_RESP;
          end else if (req_we && !hi_half) begin
            stage_d = req_wdata;
            st_d    = ST_RESP;
          end else if (!req_we && hi_half) begin
            rd_d = upper_q;
            st_d = ST_RESP;
          end else begin
            cv_d  = 1'b1;
            cwe_d = req_we;
            cad_d = idx;
            cwd_d = req_we ? {req_wdata, stage_q} : '0;
            st_d  = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (cpu_ack) begin
          cv_d = 1'b0;
          if (!cwe_q) begin
            rd_d    = cpu_rdata[DW-1:0];
            upper_d = cpu_rdata[CW-1:DW];
          end
          st_d = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cv_q    <= 1'b0;
      cwe_q   <= 1'b0;
      cad_q   <= '0;
      cwd_q   <= '0;
      upper_q <= '0;
      stage_q <= '0;
      rd_q    <= '0;
    end else begin
      st_q    <= st_d;
      cv_q    <= cv_d;
      cwe_q   <= cwe_d;
      cad_q   <= cad_d;
      cwd_q   <= cwd_d;
      upper_q <= upper_d;
      stage_q <= stage_d;
      rd_q    <= rd_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rd_q;
  assign cpu_valid = cv_q;
  assign cpu_we    = cwe_q;
  assign cpu_addr  = cad_q;
  assign cpu_wdata = cwd_q;
endmodule

// File: rtl/dbg_reg_bridge.sv
module dbg_reg_bridge #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int CPU_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic              dbg_req_we,
  input  logic [AW-1:0]     dbg_req_addr,
  input  logic [DW-1:0]     dbg_req_wdata,
  output logic              dbg_rsp_valid,
  output logic [DW-1:0]     dbg_rsp_rdata,
  output logic              dbg_event,
  output logic              cpu_stall_req,
  input  logic              cpu_stalled,
  output logic              cpu_valid,
  output logic              cpu_we,
  output logic [CPU_AW-1:0] cpu_addr,
  output logic [2*DW-1:0]   cpu_wdata,
  input  logic              cpu_ack,
  input  logic [2*DW-1:0]   cpu_rdata
);
  logic          rst_n_i;
  logic          ctrl_wr;
  logic          ctrl_wbit;
  logic          stalled_now;
  logic [DW-1:0] ctrl_word;

  dbgb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dbgb_stall u_stall (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .wr_en       (ctrl_wr),
    .wr_bit      (ctrl_wbit),
    .cpu_stalled (cpu_stalled),
    .stall_req   (cpu_stall_req),
    .stalled_now (stalled_now),
    .stall_evt   (dbg_event)
  );

  assign ctrl_word = {{(DW-2){1'b0}}, stalled_now, cpu_stall_req};

  dbgb_xfer #(.DW(DW), .AW(AW), .CPU_AW(CPU_AW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (dbg_req_valid),
    .req_ready (dbg_req_ready),
    .req_we    (dbg_req_we),
    .req_addr  (dbg_req_addr),
    .req_wdata (dbg_req_wdata),
    .rsp_valid (dbg_rsp_valid),
    .rsp_rdata (dbg_rsp_rdata),
    .ctrl_word (ctrl_word),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wbit (ctrl_wbit),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: rtl/dbgb_checker.sv
module dbgb_checker #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int CPU_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_req_valid,
  input logic              dbg_req_ready,
  input logic              dbg_rsp_valid,
  input logic              dbg_event,
  input logic              cpu_stalled,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [2*DW-1:0]   cpu_wdata,
  input logic              cpu_ack
);
  // R8: a pending processor access holds its fields until acknowledged
  p_hold_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_ack |=> cpu_valid && $stable(cpu_we) && $stable(cpu_addr) && $stable(cpu_wdata));

  // R8: no new debug request is taken while a processor access is open
  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> !dbg_req_ready);

  // R8: an accepted request closes the debug side on the next cycle
  p_accept_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid && dbg_req_ready |=> !dbg_req_ready);

  // R9: the response strobe lasts one cycle
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rsp_valid |=> !dbg_rsp_valid);

  // R9: an acknowledge is answered on the next cycle
  p_ack_answers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ack |=> dbg_rsp_valid && !cpu_valid);

  // R2: the stall event is a single-cycle pulse
  p_event_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |=> !dbg_event);

  // R2: the event follows a sampled stalled status
  p_event_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(cpu_stalled));
endmodule

bind dbg_reg_bridge dbgb_checker #(.DW(DW), .AW(AW), .CPU_AW(CPU_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dbg_req_valid (dbg_req_valid),
  .dbg_req_ready (dbg_req_ready),
  .dbg_rsp_valid (dbg_rsp_valid),
  .dbg_event     (dbg_event),
  .cpu_stalled   (cpu_stalled),
  .cpu_valid     (cpu_valid),
  .cpu_we        (cpu_we),
  .cpu_addr      (cpu_addr),
  .cpu_wdata     (cpu_wdata),
  .cpu_ack       (cpu_ack)
);

// File: tb/dbg_reg_bridge_bench.sv
module dbg_reg_bridge_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        dbg_req_valid, dbg_req_ready, dbg_req_we;
  logic [15:0] dbg_req_addr, dbg_req_wdata, dbg_rsp_rdata;
  logic        dbg_rsp_valid, dbg_event, cpu_stall_req, cpu_stalled;
  logic        cpu_valid, cpu_we, cpu_ack;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;

  dbg_reg_bridge u_dbg_reg_bridge (
    .clk(clk), .rst_n(rst_n),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_we(dbg_req_we), .dbg_req_addr(dbg_req_addr), .dbg_req_wdata(dbg_req_wdata),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_rdata(dbg_rsp_rdata),
    .dbg_event(dbg_event), .cpu_stall_req(cpu_stall_req), .cpu_stalled(cpu_stalled),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_evt = 0;
  int n_rd  = 0;
  int n_wr  = 0;
  int lat   = 0;
  logic [7:0]  last_idx;
  logic [31:0] mem [256];

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // processor model: optional wait, then a one-cycle acknowledge
  initial begin
    int w;
    w = 0;
    cpu_ack = 1'b0;
    cpu_rdata = '0;
    forever begin
      @(negedge clk);
      if (cpu_ack) begin
        cpu_ack = 1'b0;
        w = 0;
      end else if (cpu_valid) begin
        if (w >= lat) begin
          cpu_ack  = 1'b1;
          last_idx = cpu_addr;
          if (cpu_we) begin
            mem[cpu_addr] = cpu_wdata;
            n_wr++;
          end else begin
            cpu_rdata = mem[cpu_addr];
            n_rd++;
          end
        end else begin
          w++;
        end
      end
    end
  end

  // monitor: counts events, compares responses against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (dbg_event) n_evt++;
      if (dbg_rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 response without request", 32'(dbg_rsp_rdata), 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(dbg_rsp_rdata == e.val, e.tag, 32'(dbg_rsp_rdata), 32'(e.val));
        end
      end
    end
  end

  task automatic do_req(input bit we, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] exp, input string tag, input int exp_lat);
    exp_t e;
    int n;
    @(negedge clk);
    dbg_req_valid = 1'b1;
    dbg_req_we    = we;
    dbg_req_addr  = a;
    dbg_req_wdata = d;
    while (!dbg_req_ready) @(negedge clk);
    e.val = exp;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    dbg_req_valid = 1'b0;
    check(!dbg_req_ready, "R8 ready low after accept", 32'(dbg_req_ready), 32'h0);
    n = 1;
    while (!dbg_rsp_valid) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_lat, "R9 response cycle", 32'(n), 32'(exp_lat));
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    report();
  end

  initial begin
    int rd0, wr0, ev0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i);
    mem[3] = 32'hDEAD_BEEF;
    rst_n = 1'b0;
    dbg_req_valid = 1'b0;
    dbg_req_we = 1'b0;
    dbg_req_addr = '0;
    dbg_req_wdata = '0;
    cpu_stalled = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check(dbg_req_ready == 1'b1, "R11 ready", 32'(dbg_req_ready), 32'h1);
    check(dbg_rsp_valid == 1'b0, "R11 rsp_valid", 32'(dbg_rsp_valid), 32'h0);
    check(dbg_event == 1'b0, "R11 event", 32'(dbg_event), 32'h0);
    check(cpu_stall_req == 1'b0, "R11 stall_req", 32'(cpu_stall_req), 32'h0);
    check(cpu_valid == 1'b0, "R11 cpu_valid", 32'(cpu_valid), 32'h0);

    // R1 stall control word
    do_req(1'b1, 16'h0000, 16'h0001, 16'h0000, "R1 write ctrl", 1);
    check(cpu_stall_req == 1'b1, "R1 stall request set", 32'(cpu_stall_req), 32'h1);
    do_req(1'b0, 16'h0000, 16'h0000, 16'h0001, "R1 read ctrl running", 1);
    ev0 = n_evt;
    cpu_stalled = 1'b1;
    repeat (6) @(negedge clk);
    // R2 one event for one rising edge, none while stalled
    check(n_evt - ev0 == 1, "R2 single event on stall", 32'(n_evt - ev0), 32'h1);
    do_req(1'b0, 16'h0000, 16'h0000, 16'h0003, "R1 read ctrl stalled", 1);
    do_req(1'b1, 16'h0000, 16'h0000, 16'h0000, "R1 release", 1);
    check(cpu_stall_req == 1'b0, "R1 stall request cleared", 32'(cpu_stall_req), 32'h0);
    do_req(1'b0, 16'h0000, 16'h0000, 16'h0002, "R1 read ctrl released", 1);
    cpu_stalled = 1'b0;
    repeat (2) @(negedge clk);
    cpu_stalled = 1'b1;
    repeat (4) @(negedge clk);
    check(n_evt - ev0 == 2, "R2 second stall gives second event", 32'(n_evt - ev0), 32'h2);
    cpu_stalled = 1'b0;

    // R10 other local addresses
    do_req(1'b1, 16'h0005, 16'hFFFF, 16'h0000, "R10 write unused local", 1);
    do_req(1'b0, 16'h0005, 16'h0000, 16'h0000, "R10 read unused local", 1);
    check(cpu_stall_req == 1'b0, "R10 stall request untouched", 32'(cpu_stall_req), 32'h0);
    do_req(1'b0, 16'h03FF, 16'h0000, 16'h0000, "R10 read top local", 1);

    // R3 R4 low-half read of index 3
    rd0 = n_rd;
    do_req(1'b0, 16'h0406, 16'h0000, 16'hBEEF, "R4 low half read", 2);
    check(n_rd - rd0 == 1, "R4 one processor read", 32'(n_rd - rd0), 32'h1);
    check(last_idx == 8'd3, "R3 index from address", 32'(last_idx), 32'h3);
    // R5 high half from latch
    do_req(1'b0, 16'h0407, 16'h0000, 16'hDEAD, "R5 high half read", 1);
    check(n_rd - rd0 == 1, "R5 no processor access", 32'(n_rd - rd0), 32'h1);

    // R6 R7 split write to index 4
    wr0 = n_wr;
    do_req(1'b1, 16'h0408, 16'h1234, 16'h0000, "R6 low half write", 1);
    check(n_wr == wr0, "R6 no processor write", 32'(n_wr - wr0), 32'h0);
    check(mem[4] == 32'h1000_0004, "R6 register untouched", mem[4], 32'h1000_0004);
    do_req(1'b1, 16'h0409, 16'hABCD, 16'h0000, "R7 high half write", 2);
    check(n_wr - wr0 == 1, "R7 one processor write", 32'(n_wr - wr0), 32'h1);
    check(mem[4] == 32'hABCD_1234, "R7 combined word", mem[4], 32'hABCD_1234);
    check(last_idx == 8'd4, "R3 write index", 32'(last_idx), 32'h4);

    // R8 R9 with a slow processor
    lat = 3;
    do_req(1'b0, 16'h0408, 16'h0000, 16'h1234, "R8 slow low read", 5);
    do_req(1'b0, 16'h0409, 16'h0000, 16'hABCD, "R5 slow high read", 1);
    do_req(1'b1, 16'h0500, 16'h5555, 16'h0000, "R6 stage idx 128", 1);
    do_req(1'b1, 16'h0501, 16'hAAAA, 16'h0000, "R7 slow write idx 128", 5);
    check(mem[128] == 32'hAAAA_5555, "R3 R7 index 128 word", mem[128], 32'hAAAA_5555);
    // R3 truncation: (0x0600 - 0x400) >> 1 = 0x100 -> index 0
    lat = 0;
    do_req(1'b0, 16'h0600, 16'h0000, 16'h0000, "R3 wrapped index read", 2);
    check(last_idx == 8'd0, "R3 index truncated", 32'(last_idx), 32'h0);
    do_req(1'b0, 16'h0601, 16'h0000, 16'h1000, "R5 wrapped high half", 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses seen", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule